// File: doc/BRIEF.md
# Dual-Mode Count Prescaler and Input Glitch Filter

This block produces the single-cycle increment strobe for a low-power counter. It serves two modes, picked by one input. In time-counter mode it divides a selected tick source by a programmable power of two. In pulse-counter mode it filters an input pin. A new pin level counts only after it has held for a programmable number of selected ticks, and only an accepted low-to-high change bumps the counter. A bypass option skips the divider or filter. It passes the selected tick straight through in time-counter mode, or every rising edge of the pin in pulse-counter mode.

All logic runs on one clock. The four tick sources are single-cycle clock-enable strobes, and a 2-bit select chooses one of them. Mode, prescale code, bypass and select are captured while `enable` is low and frozen while it is high. Mid-run writes have no effect. The control is a state machine with five states:
- `ST_OFF`: disabled. Counters are cleared, and the accepted level follows the pin.
- `ST_DIVIDE`: the divider is running.
- `ST_BYPASS`: pass-through.
- `ST_WATCH`: the filter sees the pin at the accepted level.
- `ST_QUALIFY`: the pin differs from the accepted level, and ticks are being counted.

The transitions work as follows:
- Any state goes to `ST_OFF` when `enable` is low.
- `ST_OFF` goes to `ST_BYPASS`, `ST_DIVIDE` or `ST_WATCH` on enable, depending on the latched bypass bit and mode.
- `ST_WATCH` goes to `ST_QUALIFY` when the pin differs from the accepted level.
- `ST_QUALIFY` returns to `ST_WATCH` when the pin returns to the accepted level, or when the new level is accepted.

Top module: `lpt_prescale_filter`

## Requirements
- R1: In time-counter mode (mode = 0) with bypass clear, prescale code N gives one increment pulse per 2^(N+1) selected ticks counted after enable. The first pulse is seen in the cycle after the clock edge that samples the 2^(N+1)-th tick.
- R2: With bypass clear, every increment pulse lasts exactly one cycle and is never followed by another in the next cycle.
- R3: In pulse-counter mode (mode = 1) with bypass clear and code N ≥ 1, a pin level that differs from the accepted level is accepted once it has been sampled on 2^N selected ticks. Accepting a high level gives one pulse, in the cycle after the accepting edge. Accepting a low level gives no pulse.
- R4: If the pin returns to the accepted level before the threshold is reached, the tick count restarts from zero.
- R5: In pulse-counter mode with bypass clear, code 0 is not a valid filter width and behaves exactly as code 1 (2 ticks).
- R6: In time-counter mode with bypass set, the output equals the selected tick delayed by one cycle.
- R7: In pulse-counter mode with bypass set, each low-to-high change of the pin gives one pulse in the cycle after the edge that sees it. A steady level gives none.
- R8: Select value S (0 to 3) makes tick source bit S the only source that matters. Ticks on the other bits have no effect.
- R9: Mode, code, bypass and select are captured on every edge where `enable` is low. Changes while `enable` is high are ignored until the next disable.
- R10: While `enable` is low, the output stays low and the divider and filter counts are cleared. The pin level present at enable becomes the accepted level and gives no pulse.
- R11: After reset the output is low, the block is disabled and the captured configuration is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| enable | input | 1 | Run control; configuration is captured while low |
| mode | input | 1 | 0 = time counter, 1 = pulse counter |
| prescale | input | 4 | Divide code (2^(N+1)) or filter code (2^N ticks) |
| bypass | input | 1 | Skip divider or filter |
| clk_sel | input | 2 | Chooses one of the tick sources |
| src_tick | input | 4 | Single-cycle tick strobes, one per source |
| pin_in | input | 1 | Pulse-counter input pin |
| cnt_inc | output | 1 | Counter increment strobe |

## Verification
The checker watches four properties on every cycle:
- The output stays silent while disabled.
- The captured configuration is frozen while enabled.
- Pulses last one cycle when nothing is bypassed.
- The output follows the selected tick in time bypass, and pulses in pulse mode only after a high pin sample.

The bench scenarios are the only place that shows the quantities that take many cycles to emerge: exact divide ratios and first-pulse positions, filter thresholds, count restarts after glitches, the code-0 fallback, source selection, and the effect of a disable midway through a count.

// File: rtl/lpt_pkg.sv
package lpt_pkg;
    localparam int CODE_W = 4;
    localparam int CNT_W  = 1 << CODE_W;

    typedef enum logic [2:0] {
        ST_OFF,
        ST_DIVIDE,
        ST_BYPASS,
        ST_WATCH,
        ST_QUALIFY
    } lpt_state_e;

    localparam logic MODE_TIME  = 1'b0;
    localparam logic MODE_PULSE = 1'b1;
endpackage

// File: rtl/lpt_cfg_hold.sv
module lpt_cfg_hold #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         enable,
    input  logic [W-1:0] cfg_in,
    output logic [W-1:0] cfg_q
);
    // Capture while stopped, freeze while running.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            cfg_q <= '0;
        else if (!enable)
            cfg_q <= cfg_in;
    end
endmodule

// File: rtl/lpt_tick_sel.sv
module lpt_tick_sel #(
    parameter int N_SRC = 4,
    localparam int SEL_W = (N_SRC > 1) ? $clog2(N_SRC) : 1
) (
    input  logic [N_SRC-1:0] src_tick,
    input  logic [SEL_W-1:0] sel,
    output logic             tick
);
    always_comb begin
        tick = 1'b0;
        for (int i = 0; i < N_SRC; i++)
            if (SEL_W'(i) == sel)
                tick = src_tick[i];
    end
endmodule

// File: rtl/lpt_term_dec.sv
module lpt_term_dec
    import lpt_pkg::*;
(
    input  logic              mode,
    input  logic [CODE_W-1:0] code,
    output logic [CNT_W-1:0]  term
);
    logic [CODE_W:0] shift;
    logic [CNT_W:0]  span;

    // Terminal count = (number of ticks per event) - 1.
    always_comb begin
        if (mode == MODE_TIME)
            shift = {1'b0, code} + 1'b1;
        else if (code == '0)
            shift = 1;
        else
            shift = {1'b0, code};
        span = (CNT_W+1)'(1) << shift;
        term = CNT_W'(span - 1'b1);
    end
endmodule

// File: rtl/lpt_prescale_filter.sv
module lpt_prescale_filter
    import lpt_pkg::*;
#(
    parameter int N_SRC = 4,
    localparam int SEL_W = (N_SRC > 1) ? $clog2(N_SRC) : 1,
    localparam int CFG_W = 1 + CODE_W + 1 + SEL_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              enable,
    input  logic              mode,
    input  logic [CODE_W-1:0] prescale,
    input  logic              bypass,
    input  logic [SEL_W-1:0]  clk_sel,
    input  logic [N_SRC-1:0]  src_tick,
    input  logic              pin_in,
    output logic              cnt_inc
);
    logic [CFG_W-1:0]  cfg_q;
    logic              cfg_mode_q;
    logic [CODE_W-1:0] cfg_code_q;
    logic              cfg_byp_q;
    logic [SEL_W-1:0]  cfg_sel_q;
    logic              tick_sel;
    logic [CNT_W-1:0]  term;

    lpt_state_e        state_q, state_nx;
    logic [CNT_W-1:0]  cnt_q, cnt_nx;
    logic              acc_q, acc_nx;
    logic              fire;

    lpt_cfg_hold #(.W(CFG_W)) u_cfg (
        .clk    (clk),
        .rst_n  (rst_n),
        .enable (enable),
        .cfg_in ({mode, prescale, bypass, clk_sel}),
        .cfg_q  (cfg_q)
    );

    assign {cfg_mode_q, cfg_code_q, cfg_byp_q, cfg_sel_q} = cfg_q;

    lpt_tick_sel #(.N_SRC(N_SRC)) u_sel (
        .src_tick (src_tick),
        .sel      (cfg_sel_q),
        .tick     (tick_sel)
    );

    lpt_term_dec u_term (
        .mode (cfg_mode_q),
        .code (cfg_code_q),
        .term (term)
    );

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            state_q <= ST_OFF;
        else
            state_q <= state_nx;
    end

    // Datapath registers: tick count and accepted pin level
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
            acc_q <= 1'b0;
        end else begin
            cnt_q <= cnt_nx;
            acc_q <= acc_nx;
        end
    end

    // Next state and event decision
    always_comb begin
        state_nx = state_q;
        cnt_nx   = cnt_q;
        acc_nx   = acc_q;
        fire     = 1'b0;
        if (!enable) begin
            state_nx = ST_OFF;
            cnt_nx   = '0;
            acc_nx   = pin_in;
        end else begin
            unique case (state_q)
                ST_OFF: begin
                    cnt_nx = '0;
                    acc_nx = pin_in;
                    if (cfg_byp_q)
                        state_nx = ST_BYPASS;
                    else if (cfg_mode_q == MODE_TIME)
                        state_nx = ST_DIVIDE;
                    else
                        state_nx = ST_WATCH;
                end
                ST_DIVIDE: begin
                    if (tick_sel) begin
                        if (cnt_q == term) begin
                            cnt_nx = '0;
                            fire   = 1'b1;
                        end else begin
                            cnt_nx = cnt_q + 1'b1;
                        end
                    end
                end
                ST_BYPASS: begin
                    acc_nx = pin_in;
                    if (cfg_mode_q == MODE_TIME)
                        fire = tick_sel;
                    else
                        fire = pin_in & ~acc_q;
                end
                ST_WATCH: begin
                    if (pin_in != acc_q) begin
                        state_nx = ST_QUALIFY;
                        cnt_nx   = tick_sel ? CNT_W'(1) : '0;
                    end
                end
                ST_QUALIFY: begin
                    if (pin_in == acc_q) begin
                        state_nx = ST_WATCH;
                        cnt_nx   = '0;
                    end else if (tick_sel) begin
                        if (cnt_q == term) begin
                            state_nx = ST_WATCH;
                            cnt_nx   = '0;
                            acc_nx   = pin_in;
                            fire     = pin_in;
                        end else begin
                            cnt_nx = cnt_q + 1'b1;
                        end
                    end
                end
                default: state_nx = ST_OFF;
            endcase
        end
    end

    // Output register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            cnt_inc <= 1'b0;
        else
            cnt_inc <= fire;
    end
endmodule

// File: rtl/lpt_prescale_filter_chk.sv
module lpt_prescale_filter_chk
    import lpt_pkg::*;
#(
    parameter int CFG_W = 8
) (
    input logic             clk,
    input logic             rst_n,
    input logic             enable,
    input logic             pin_in,
    input logic             cnt_inc,
    input logic [CFG_W-1:0] cfg_q,
    input logic             cfg_mode_q,
    input logic             cfg_byp_q,
    input logic             tick_sel,
    input lpt_state_e       state_q
);
    AST_OFF_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
        !enable |=> !cnt_inc); // R10

    AST_CFG_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
        enable |=> $stable(cfg_q)); // R9

    AST_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt_inc && !cfg_byp_q) |=> !cnt_inc); // R2

    AST_BYP_FOLLOW: assert property (@(posedge clk) disable iff (!rst_n)
        (enable && state_q == ST_BYPASS && cfg_mode_q == MODE_TIME)
            |=> (cnt_inc == $past(tick_sel))); // R6

    AST_PULSE_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt_inc && cfg_mode_q == MODE_PULSE) |-> $past(pin_in)); // R3
endmodule

bind lpt_prescale_filter lpt_prescale_filter_chk #(.CFG_W(CFG_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .enable     (enable),
    .pin_in     (pin_in),
    .cnt_inc    (cnt_inc),
    .cfg_q      (cfg_q),
    .cfg_mode_q (cfg_mode_q),
    .cfg_byp_q  (cfg_byp_q),
    .tick_sel   (tick_sel),
    .state_q    (state_q)
);

// File: tb/tb_lpt_prescale_filter.sv
module tb_lpt_prescale_filter;
    localparam int CLK_PERIOD = 10;
    localparam int VEC_N = 8;
    localparam int V_CODE [VEC_N] = '{0, 1, 2, 3, 4, 5, 7, 15};
    localparam int V_TICK [VEC_N] = '{9, 16, 23, 48, 31, 64, 512, 65536};
    localparam int V_PULS [VEC_N] = '{4, 4, 2, 3, 0, 1, 2, 1};

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       enable = 1'b0;
    logic       mode = 1'b0;
    logic [3:0] prescale = '0;
    logic       bypass = 1'b0;
    logic [1:0] clk_sel = '0;
    logic [3:0] src_tick = '0;
    logic       pin_in = 1'b0;
    logic       cnt_inc;

    int total = 0;
    int bad = 0;
    int lane = 0;
    int np, fp;

    lpt_prescale_filter dut (
        .clk(clk), .rst_n(rst_n), .enable(enable), .mode(mode),
        .prescale(prescale), .bypass(bypass), .clk_sel(clk_sel),
        .src_tick(src_tick), .pin_in(pin_in), .cnt_inc(cnt_inc)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic check(input string req, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // Called at a negedge: configure while stopped, then start.
    task automatic start(input logic m, input int code, input logic byp,
                         input int sel);
        enable   = 1'b0;
        mode     = m;
        prescale = 4'(code);
        bypass   = byp;
        clk_sel  = 2'(sel);
        lane     = sel;
        src_tick = '0;
        @(negedge clk);
        @(negedge clk);
        enable = 1'b1;
        @(negedge clk);
    endtask

    // Drive n cycles with the given tick and pin levels; count pulses.
    task automatic run(input int n, input logic tk, input logic pn,
                       output int pulses, output int first);
        pulses = 0;
        first  = 0;
        for (int i = 1; i <= n; i++) begin
            src_tick = tk ? (4'b0001 << lane) : 4'b0000;
            pin_in   = pn;
            @(negedge clk);
            if (cnt_inc) begin
                pulses++;
                if (first == 0) first = i;
            end
        end
        src_tick = '0;
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        bad++;
        total++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        check("R11 reset output", int'(cnt_inc), 0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R11 idle after reset", int'(cnt_inc), 0);

        // Vector table: time-counter divide ratios
        for (int v = 0; v < VEC_N; v++) begin
            int lim;
            lim = 2 << V_CODE[v];
            start(1'b0, V_CODE[v], 1'b0, 0);
            run(V_TICK[v], 1'b1, 1'b0, np, fp);
            check("R1 pulse count", np, V_PULS[v]);
            check("R1 first pulse tick", fp, (V_TICK[v] >= lim) ? lim : 0);
        end

        // R2: pulses one cycle apart are impossible at divide-by-2
        start(1'b0, 0, 1'b0, 0);
        run(1, 1'b1, 1'b0, np, fp);
        run(1, 1'b1, 1'b0, np, fp);
        check("R2 pulse after second tick", np, 1);
        run(1, 1'b0, 1'b0, np, fp);
        check("R2 no repeat pulse", np, 0);

        // R9: code change while enabled is ignored
        start(1'b0, 0, 1'b0, 0);
        prescale = 4'd3;
        mode     = 1'b1;
        run(8, 1'b1, 1'b0, np, fp);
        check("R9 mid-run write ignored", np, 4);

        // R10: disable clears the divider
        start(1'b0, 2, 1'b0, 0);
        run(5, 1'b1, 1'b0, np, fp);
        enable = 1'b0;
        run(3, 1'b1, 1'b1, np, fp);
        check("R10 silent while disabled", np, 0);
        enable = 1'b1;
        @(negedge clk);
        run(7, 1'b1, 1'b0, np, fp);
        check("R10 count cleared", np, 0);
        run(1, 1'b1, 1'b0, np, fp);
        check("R10 full count after restart", np, 1);

        // R8: only the selected source counts
        start(1'b0, 0, 1'b0, 2);
        lane = 1;
        run(8, 1'b1, 1'b0, np, fp);
        check("R8 other source ignored", np, 0);
        lane = 2;
        run(8, 1'b1, 1'b0, np, fp);
        check("R8 selected source", np, 4);

        // R6: time bypass
        start(1'b0, 5, 1'b1, 3);
        run(5, 1'b1, 1'b0, np, fp);
        check("R6 bypass every tick", np, 5);
        check("R6 bypass latency", fp, 1);

        // R3/R4: filter, code 3 -> 8 ticks
        pin_in = 1'b0;
        start(1'b1, 3, 1'b0, 0);
        run(7, 1'b1, 1'b1, np, fp);
        check("R3 short high rejected", np, 0);
        run(1, 1'b1, 1'b0, np, fp);
        check("R4 glitch back to low", np, 0);
        run(8, 1'b1, 1'b1, np, fp);
        check("R4 restart then accept", fp, 8);
        run(8, 1'b1, 1'b0, np, fp);
        check("R3 falling accepted silently", np, 0);
        run(5, 1'b1, 1'b1, np, fp);
        run(1, 1'b1, 1'b0, np, fp);
        run(8, 1'b1, 1'b1, np, fp);
        check("R4 count restarted", fp, 8);

        // R3: sparse ticks, code 1 -> 2 ticks
        pin_in = 1'b0;
        start(1'b1, 1, 1'b0, 1);
        run(1, 1'b0, 1'b1, np, fp);
        run(1, 1'b1, 1'b1, np, fp);
        run(1, 1'b0, 1'b1, np, fp);
        check("R3 needs two ticks", np, 0);
        run(1, 1'b1, 1'b1, np, fp);
        check("R3 accept on second tick", np, 1);

        // R5: code 0 filter behaves as code 1
        pin_in = 1'b0;
        start(1'b1, 0, 1'b0, 0);
        run(4, 1'b1, 1'b1, np, fp);
        check("R5 code0 threshold", fp, 2);

        // R10: pin high at enable is the accepted level
        pin_in = 1'b1;
        start(1'b1, 1, 1'b0, 0);
        run(4, 1'b1, 1'b1, np, fp);
        check("R10 level at enable not counted", np, 0);

        // R7: pulse bypass
        pin_in = 1'b0;
        start(1'b1, 4, 1'b1, 0);
        run(3, 1'b0, 1'b1, np, fp);
        check("R7 one pulse per rise", np, 1);
        check("R7 bypass latency", fp, 1);
        run(2, 1'b0, 1'b0, np, fp);
        check("R7 fall no pulse", np, 0);
        run(1, 1'b0, 1'b1, np, fp);
        check("R7 second rise", np, 1);

        enable = 1'b0;
        @(negedge clk);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule